// File: doc/BRIEF.md
# Presettable Up/Down Counter with Binary or Decade Modulus

A single counting stage of a small width (four bits by default) that steps up or down by one on each rising clock edge. Two static select inputs set its behaviour. One chooses the direction. The other chooses whether the stage wraps over the full binary range or over a decade range from 0 to 9. A level-sensitive preset copies a parallel load word into the count straight away, without waiting for the clock. While the preset is high it also blocks all counting.

An active-low carry input enables counting. An active-low carry output signals that the stage sits at its terminal value for the selected direction. The carry output is combinational, so it can feed the carry input of the next stage directly. Stages chained this way share one clock and form a multi-digit counter: each higher stage steps only on the edge where every lower stage is at its terminal value.

Top module: `updn_modctr`

## Requirements
- R1: While `load_en` is 1, `q` follows `load_val` without any clock edge. All 16 codes 0..15 can be loaded in either mode.
- R2: While `load_en` is 1, clock edges do not change `q`. After `load_en` falls, `q` keeps the loaded value until the next rising edge. The first count happens on that edge.
- R3: With `load_en` at 0 and `cnt_en_n` at 1, `q` does not change on a rising clock edge.
- R4: With `radix_bin`=1, `dir_up`=1 and `cnt_en_n`=0, each rising edge moves `q` to (q+1) mod 16, so 15 is followed by 0.
- R5: With `radix_bin`=1, `dir_up`=0 and `cnt_en_n`=0, each rising edge moves `q` to (q-1) mod 16, so 0 is followed by 15.
- R6: With `radix_bin`=0, `dir_up`=1 and `cnt_en_n`=0, the count steps from 0 up to 9 and then wraps from 9 to 0.
- R7: With `radix_bin`=0, `dir_up`=0 and `cnt_en_n`=0, the count steps down by one and wraps from 0 to 9.
- R8: In decade mode, a loaded value of 10..15 goes to 0 on an up count and to the value minus one on a down count.
- R9: With `cnt_en_n`=0, `carry_n` is 0 exactly when `dir_up`=1 and `q` equals the mode maximum (15 in binary, 9 in decade), or when `dir_up`=0 and `q` is 0. Otherwise it is 1. In decade mode, 10..15 are never terminal.
- R10: While `cnt_en_n` is 1, `carry_n` is 1 for every count and mode.
- R11: Two stages on one clock, with the low stage's `carry_n` wired to the high stage's `cnt_en_n`, count as one two-digit counter of modulus 100 (decade) or 256 (binary) in either direction. The high stage's `carry_n` is 0 only when both stages are terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| load_en | input | 1 | Asynchronous preset, active high; loads `load_val` and blocks counting |
| load_val | input | CNT_W | Parallel preset word |
| radix_bin | input | 1 | 1 = binary modulus, 0 = decade modulus |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| cnt_en_n | input | 1 | Active-low count enable / carry input from the lower stage |
| q | output | CNT_W | Current count |
| carry_n | output | 1 | Active-low terminal-count flag / carry to the next stage |

## Verification
The checker assumes that `load_val` stays steady at every clock edge while the preset is high and across the release. Its clocked properties are switched off for any cycle that a preset pulse touches, including pulses that rise and fall between two edges. The bench changes the load word only while the clock is low, and holds the preset across whole cycles except in the scenario that probes the asynchronous load between edges. The mode and direction selects change only at the falling edge, so the value each stage samples at the next rising edge is unambiguous.

// File: rtl/updn_modctr_pkg.sv
package updn_modctr_pkg;
   typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
   typedef enum logic {RADIX_DEC = 1'b0, RADIX_BIN = 1'b1} radix_e;
   localparam int unsigned DEF_CNT_W   = 4;
   localparam int unsigned DEF_DEC_MAX = 9;
endpackage

// File: rtl/modctr_limit.sv
// Selects the wrap value for the active modulus.
module modctr_limit #(
   parameter int unsigned CNT_W   = updn_modctr_pkg::DEF_CNT_W,
   parameter int unsigned DEC_MAX = updn_modctr_pkg::DEF_DEC_MAX
) (
   input  logic             radix_bin,
   output logic [CNT_W-1:0] lim
);
   import updn_modctr_pkg::*;
   localparam logic [CNT_W-1:0] BIN_TOP = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(DEC_MAX);

   generate
      if (DEC_MAX == (2**CNT_W) - 1) begin : g_same_top
         // both moduli coincide; the select has no effect
         assign lim = BIN_TOP;
      end else begin : g_two_top
         assign lim = (radix_e'(radix_bin) == RADIX_BIN) ? BIN_TOP : DEC_TOP;
      end
   endgenerate
endmodule

// File: rtl/modctr_step.sv
// Next count for one enabled step in the chosen direction.
module modctr_step #(
   parameter int unsigned CNT_W = updn_modctr_pkg::DEF_CNT_W
) (
   input  logic [CNT_W-1:0] cur,
   input  logic [CNT_W-1:0] lim,
   input  logic             dir_up,
   output logic [CNT_W-1:0] nxt
);
   import updn_modctr_pkg::*;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_comb begin
      if (dir_e'(dir_up) == DIR_UP) begin
         // values at or above the limit (decade 10..15) restart at zero
         nxt = (cur >= lim) ? '0 : cur + ONE;
      end else begin
         nxt = (cur == '0) ? lim : cur - ONE;
      end
   end
endmodule

// File: rtl/modctr_term.sv
// Active-low terminal-count flag, combinational for ripple chaining.
module modctr_term #(
   parameter int unsigned CNT_W = updn_modctr_pkg::DEF_CNT_W
) (
   input  logic [CNT_W-1:0] cur,
   input  logic [CNT_W-1:0] lim,
   input  logic             dir_up,
   input  logic             cnt_en_n,
   output logic             carry_n
);
   logic at_end;

   always_comb begin
      at_end  = dir_up ? (cur == lim) : (cur == '0);
      carry_n = ~(at_end & ~cnt_en_n);
   end
endmodule

// File: rtl/updn_modctr.sv
module updn_modctr #(
   parameter int unsigned CNT_W   = updn_modctr_pkg::DEF_CNT_W,
   parameter int unsigned DEC_MAX = updn_modctr_pkg::DEF_DEC_MAX
) (
   input  logic             clk,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             radix_bin,
   input  logic             dir_up,
   input  logic             cnt_en_n,
   output logic [CNT_W-1:0] q,
   output logic             carry_n
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("updn_modctr: CNT_W must lie in 2..16");
      end
      if (DEC_MAX < 1 || DEC_MAX > (2**CNT_W) - 1) begin : g_bad_dec
         $error("updn_modctr: DEC_MAX must lie in 1..2**CNT_W-1");
      end
   endgenerate

   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] cnt_q;

   modctr_limit #(.CNT_W(CNT_W), .DEC_MAX(DEC_MAX)) u_limit (
      .radix_bin (radix_bin),
      .lim       (lim)
   );

   modctr_step #(.CNT_W(CNT_W)) u_step (
      .cur    (cnt_q),
      .lim    (lim),
      .dir_up (dir_up),
      .nxt    (nxt)
   );

   modctr_term #(.CNT_W(CNT_W)) u_term (
      .cur      (cnt_q),
      .lim      (lim),
      .dir_up   (dir_up),
      .cnt_en_n (cnt_en_n),
      .carry_n  (carry_n)
   );

   // preset acts as an asynchronous load; its release only clears the
   // override, so no step happens until the following rising edge
   always_ff @(posedge clk or posedge load_en) begin
      if (load_en) begin
         cnt_q <= load_val;
      end else if (!cnt_en_n) begin
         cnt_q <= nxt;
      end
   end

   assign q = cnt_q;
endmodule

// File: rtl/updn_modctr_chk.sv
module updn_modctr_chk #(
   parameter int unsigned CNT_W   = updn_modctr_pkg::DEF_CNT_W,
   parameter int unsigned DEC_MAX = updn_modctr_pkg::DEF_DEC_MAX
) (
   input logic             clk,
   input logic             load_en,
   input logic [CNT_W-1:0] load_val,
   input logic             radix_bin,
   input logic             dir_up,
   input logic             cnt_en_n,
   input logic [CNT_W-1:0] q,
   input logic             carry_n
);
   localparam logic [CNT_W-1:0] BIN_TOP = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(DEC_MAX);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   // remembers that a preset pulse occurred since the last rising edge
   logic ld_seen;
   always_ff @(posedge clk or posedge load_en) begin
      if (load_en) ld_seen <= 1'b1;
      else         ld_seen <= 1'b0;
   end

   logic [CNT_W-1:0] top_now;
   assign top_now = radix_bin ? BIN_TOP : DEC_TOP;

   // R1
   preset_copy_chk: assert property (@(posedge clk)
      load_en |-> (q == load_val));

   // R2
   release_no_step_chk: assert property (@(posedge clk)
      $fell(load_en) |-> (q == $past(load_val)));

   // R3
   hold_when_blocked_chk: assert property (@(posedge clk) disable iff (load_en || ld_seen)
      cnt_en_n |=> $stable(q));

   // R4
   bin_up_chk: assert property (@(posedge clk) disable iff (load_en || ld_seen)
      (!cnt_en_n && dir_up && radix_bin) |=> (q == $past(q) + ONE));

   // R5
   bin_down_chk: assert property (@(posedge clk) disable iff (load_en || ld_seen)
      (!cnt_en_n && !dir_up && radix_bin) |=> (q == $past(q) - ONE));

   // R6 R8
   dec_up_chk: assert property (@(posedge clk) disable iff (load_en || ld_seen)
      (!cnt_en_n && dir_up && !radix_bin) |=>
         (q == (($past(q) >= DEC_TOP) ? '0 : $past(q) + ONE)));

   // R7 R8
   dec_down_chk: assert property (@(posedge clk) disable iff (load_en || ld_seen)
      (!cnt_en_n && !dir_up && !radix_bin) |=>
         (q == (($past(q) == '0) ? DEC_TOP : $past(q) - ONE)));

   // R9
   term_flag_chk: assert property (@(posedge clk) disable iff (load_en)
      !cnt_en_n |-> (carry_n == !(dir_up ? (q == top_now) : (q == '0))));

   // R10
   carry_blocked_chk: assert property (@(posedge clk) disable iff (load_en)
      cnt_en_n |-> carry_n);
endmodule

bind updn_modctr updn_modctr_chk #(.CNT_W(CNT_W), .DEC_MAX(DEC_MAX)) u_chk (
   .clk       (clk),
   .load_en   (load_en),
   .load_val  (load_val),
   .radix_bin (radix_bin),
   .dir_up    (dir_up),
   .cnt_en_n  (cnt_en_n),
   .q         (q),
   .carry_n   (carry_n)
);

// File: tb/tb_updn_modctr.sv
module tb_updn_modctr;
   logic       clk = 1'b0;
   logic       load_en;
   logic [3:0] val_lo, val_hi;
   logic       radix_bin, dir_up, cnt_en_n;
   logic [3:0] q_lo, q_hi;
   logic       carry_lo, carry_hi;
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done  = 0;

   always #5 clk = ~clk;

   updn_modctr dut (
      .clk(clk), .load_en(load_en), .load_val(val_lo), .radix_bin(radix_bin),
      .dir_up(dir_up), .cnt_en_n(cnt_en_n), .q(q_lo), .carry_n(carry_lo));

   updn_modctr dut_hi (
      .clk(clk), .load_en(load_en), .load_val(val_hi), .radix_bin(radix_bin),
      .dir_up(dir_up), .cnt_en_n(carry_lo), .q(q_hi), .carry_n(carry_hi));

   task automatic check(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int top_of(bit bin);
      return bin ? 15 : 9;
   endfunction

   function automatic int f_next(int v, bit up, bit bin);
      int t = top_of(bin);
      if (up) return (v >= t) ? 0 : v + 1;
      return (v == 0) ? t : v - 1;
   endfunction

   function automatic bit f_term(int v, bit up, bit bin);
      return up ? (v == top_of(bin)) : (v == 0);
   endfunction

   // preset both stages across one rising edge
   task automatic preset(int lo, int hi);
      @(negedge clk);
      val_lo = 4'(lo); val_hi = 4'(hi); load_en = 1'b1;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic t_reset_state();
      check("R1", "q after first preset", int'(q_lo), 0);
      check("R10", "carry_n with count blocked", int'(carry_lo), 1);
   endtask

   task automatic t_async_load();
      cnt_en_n = 1'b1;
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         radix_bin = v[0];
         #1 val_lo = 4'(v); load_en = 1'b1;
         #1 check("R1", "async load", int'(q_lo), v);
         check("R10", "carry_n blocked", int'(carry_lo), 1);
         #1 load_en = 1'b0;
      end
   endtask

   task automatic t_hold();
      radix_bin = 1'b1; dir_up = 1'b1; cnt_en_n = 1'b1;
      preset(6, 0);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #2;
         check("R3", "hold with cnt_en_n=1", int'(q_lo), 6);
      end
   endtask

   task automatic t_override();
      radix_bin = 1'b1; dir_up = 1'b1;
      @(negedge clk);
      cnt_en_n = 1'b0; val_lo = 4'd11; val_hi = 4'd0; load_en = 1'b1;
      for (int i = 0; i < 2; i++) begin
         @(posedge clk); #2;
         check("R2", "no count while preset", int'(q_lo), 11);
      end
      @(negedge clk);
      load_en = 1'b0;
      #1 check("R2", "value right after release", int'(q_lo), 11);
      @(posedge clk); #2;
      check("R2", "first count after release", int'(q_lo), 12);
      @(negedge clk);
      cnt_en_n = 1'b1;
   endtask

   task automatic t_run(string req, bit up, bit bin, int start, int steps);
      int exp = start;
      @(negedge clk);
      cnt_en_n = 1'b1; dir_up = up; radix_bin = bin;
      preset(start, 0);
      cnt_en_n = 1'b0;
      #1 check("R9", "carry_n before step", int'(carry_lo), f_term(exp, up, bin) ? 0 : 1);
      for (int i = 0; i < steps; i++) begin
         @(posedge clk); #2;
         exp = f_next(exp, up, bin);
         check(req, "count", int'(q_lo), exp);
         check("R9", "carry_n", int'(carry_lo), f_term(exp, up, bin) ? 0 : 1);
      end
      @(negedge clk);
      cnt_en_n = 1'b1;
   endtask

   task automatic t_out_of_range();
      radix_bin = 1'b0; dir_up = 1'b1; cnt_en_n = 1'b1;
      preset(12, 0);
      cnt_en_n = 1'b0;
      #1 check("R8", "12 not terminal up", int'(carry_lo), 1);
      @(posedge clk); #2;
      check("R8", "12 up goes to 0", int'(q_lo), 0);
      @(negedge clk);
      cnt_en_n = 1'b1; dir_up = 1'b0;
      preset(13, 0);
      cnt_en_n = 1'b0;
      #1 check("R8", "13 not terminal down", int'(carry_lo), 1);
      @(posedge clk); #2;
      check("R8", "13 down goes to 12", int'(q_lo), 12);
      @(negedge clk);
      cnt_en_n = 1'b1;
   endtask

   task automatic t_cascade(bit up, bit bin, int lo, int hi, int steps);
      int m = bin ? 16 : 10;
      int v = hi * m + lo;
      @(negedge clk);
      cnt_en_n = 1'b1; dir_up = up; radix_bin = bin;
      preset(lo, hi);
      cnt_en_n = 1'b0;
      for (int i = 0; i < steps; i++) begin
         @(posedge clk); #2;
         v = up ? (v + 1) % (m * m) : (v + m * m - 1) % (m * m);
         check("R11", "low digit", int'(q_lo), v % m);
         check("R11", "high digit", int'(q_hi), v / m);
         check("R11", "chain carry_n", int'(carry_hi),
               (f_term(v % m, up, bin) && f_term(v / m, up, bin)) ? 0 : 1);
      end
      @(negedge clk);
      cnt_en_n = 1'b1;
   endtask

   initial begin
      load_en = 1'b1; val_lo = 4'd0; val_hi = 4'd0;
      radix_bin = 1'b1; dir_up = 1'b1; cnt_en_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      load_en = 1'b0;
      #1 t_reset_state();
      t_async_load();
      t_hold();
      t_override();
      t_run("R4", 1'b1, 1'b1, 13, 6);
      t_run("R5", 1'b0, 1'b1, 2, 5);
      t_run("R6", 1'b1, 1'b0, 0, 12);
      t_run("R7", 1'b0, 1'b0, 3, 6);
      t_out_of_range();
      t_cascade(1'b1, 1'b0, 7, 9, 25);
      t_cascade(1'b0, 1'b0, 2, 0, 15);
      t_cascade(1'b1, 1'b1, 14, 15, 20);
      t_cascade(1'b0, 1'b1, 1, 0, 20);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule